// File: doc/BRIEF.md
# Segmented Two-Channel Converter Input Decoder

This block is the digital front end of a two-channel, 10-bit current-steering converter. The two channels are called I and Q. Each channel has its own clock and its own synchronous active-low reset. On each rising edge of its clock, a channel takes in an unsigned 10-bit code. The code is split into two fields. The upper five bits become a 31-line thermometer word that drives equal-weight unit sources. The lower five bits pass straight through as controls for binary-weighted sources.

A second register stage captures both switch groups together, so that all of a channel's switches change on the same edge. This gives a fixed latency of two clock edges. One shared, active-high low-power input turns every source of a channel off on that channel's next edge.

For each channel, the block also outputs two integer weight figures. The true figure is rebuilt from the registered switch controls. The complementary figure is what the complementary output carries. These figures let the switch decoding be checked against the code.

Top module: `seg_dac_frontend`

## Requirements
- R1: While the channel's reset input is low at a rising edge of its clock, all 31 thermometer lines and all 5 binary lines clear to 0. After that edge the true weight reads 0 and the complementary weight reads 1023.
- R2: A code present at rising edge k reaches the switch controls and the weight outputs just after edge k+1 and not before. The outputs after edge k still show the earlier code.
- R3: The thermometer word has line j (0 to 30) set exactly when j is less than code bits [9:5]. The number of lines set therefore equals the value of the upper field.
- R4: The binary control bits [4:0] equal code bits [4:0], without any decoding.
- R5: When the code steps from a value with code bits [4:0] all ones to the next value, all five binary bits go to 0 and exactly one more thermometer line turns on.
- R6: The true weight is 32 times the number of thermometer lines set, plus the binary field. It equals the registered code for every code from 0 to 1023. Code 1023 gives 1023 and code 0 gives 0.
- R7: When not in sleep, the complementary weight is 1023 minus the code, so the two weights always sum to 1023.
- R8: When the sleep input is high at a rising edge of a channel's clock, every switch control and both weights of that channel are 0 after that edge. At the first edge with sleep low, the channel again shows the decode of its stage-one code.
- R9: The two channels are independent. A reset or a clock on one channel does not change the outputs of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| i_clk | input | 1 | I channel clock, rising edge active |
| i_rst_n | input | 1 | I channel synchronous reset, active low |
| i_code | input | 10 | I channel unsigned code |
| q_clk | input | 1 | Q channel clock, rising edge active |
| q_rst_n | input | 1 | Q channel synchronous reset, active low |
| q_code | input | 10 | Q channel unsigned code |
| sleep | input | 1 | Low-power request for both channels, active high |
| i_therm | output | 31 | I thermometer switch controls |
| i_bin | output | 5 | I binary switch controls |
| i_wt_true | output | 10 | I true-output weight in LSB units |
| i_wt_comp | output | 10 | I complementary-output weight in LSB units |
| q_therm | output | 31 | Q thermometer switch controls |
| q_bin | output | 5 | Q binary switch controls |
| q_wt_true | output | 10 | Q true-output weight in LSB units |
| q_wt_comp | output | 10 | Q complementary-output weight in LSB units |

## Verification
A corrupted stage-one code shows up one edge later in both switch groups and in both weights. A fault in the upper-field decoder shows up as a thermometer word with a gap, or with the wrong population, on the edge after the code is captured. The true weight then differs from the code by a multiple of 32. A slip in register alignment between the two groups shows up as a wrong weight at every 32-code carry during a ramp. A sleep gate that leaks shows up as nonzero controls on the first edge that samples sleep high.

// File: rtl/seg_dac_pkg.sv
// Shared sizing for the segmented converter front end.
// Assumes the code splits into an upper thermometer field and a lower binary field.
package seg_dac_pkg;
    localparam int CODE_W   = 10;
    localparam int SEG_W    = 5;
    localparam int BIN_W    = CODE_W - SEG_W;
    localparam int NSEG     = (1 << SEG_W) - 1;
    localparam int FULL_SCL = (1 << CODE_W) - 1;
endpackage

// File: rtl/seg_thermo_decoder.sv
// Turns the upper code field into a thermometer word, lowest line first.
// Assumes the field value never exceeds NSEG (true by width). Purely combinational.
module seg_thermo_decoder #(
    parameter int SEG_W = seg_dac_pkg::SEG_W,
    localparam int NSEG = (1 << SEG_W) - 1
) (
    input  logic [SEG_W-1:0] upper,
    output logic [NSEG-1:0]  therm
);
    // One comparator per segment line.
    for (genvar g = 0; g < NSEG; g++) begin : g_line
        assign therm[g] = (int'(upper) > g);
    end
endmodule

// File: rtl/seg_weight_sum.sv
// Rebuilds the integer weight of the true and complementary outputs from the
// registered switch controls. Assumes the switch controls are already registered.
module seg_weight_sum #(
    parameter int SEG_W  = seg_dac_pkg::SEG_W,
    parameter int BIN_W  = seg_dac_pkg::BIN_W,
    localparam int NSEG  = (1 << SEG_W) - 1,
    localparam int CODE_W = SEG_W + BIN_W,
    localparam int FULL  = (1 << CODE_W) - 1
) (
    input  logic [NSEG-1:0]   therm,
    input  logic [BIN_W-1:0]  bin,
    input  logic              asleep,
    output logic [CODE_W-1:0] wt_true,
    output logic [CODE_W-1:0] wt_comp
);
    logic [SEG_W-1:0] seg_cnt;

    // Population count of the segment lines.
    always_comb begin
        seg_cnt = '0;
        for (int j = 0; j < NSEG; j++) begin
            seg_cnt = seg_cnt + SEG_W'(therm[j]);
        end
    end

    // Unit segments weigh 2**BIN_W each; binary bits add their own weight.
    always_comb begin
        wt_true = {seg_cnt, bin};
        wt_comp = asleep ? '0 : CODE_W'(FULL) - wt_true;
    end
endmodule

// File: rtl/seg_channel.sv
// One converter channel: a code register, a decode stage and an aligned switch
// register, with sleep gating on the switch register. Assumes a synchronous
// active-low reset in this channel's clock domain.
module seg_channel #(
    parameter int SEG_W  = seg_dac_pkg::SEG_W,
    parameter int BIN_W  = seg_dac_pkg::BIN_W,
    localparam int NSEG  = (1 << SEG_W) - 1,
    localparam int CODE_W = SEG_W + BIN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    input  logic              sleep,
    output logic [NSEG-1:0]   therm,
    output logic [BIN_W-1:0]  bin,
    output logic [CODE_W-1:0] wt_true,
    output logic [CODE_W-1:0] wt_comp
);
    logic [CODE_W-1:0] code_q;
    logic [NSEG-1:0]   therm_d;
    logic              asleep_q;

    // Stage one: capture the raw code.
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code;
    end

    seg_thermo_decoder #(.SEG_W(SEG_W)) u_dec (
        .upper (code_q[CODE_W-1:BIN_W]),
        .therm (therm_d)
    );

    // Stage two: register both switch groups together, gated by sleep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            therm    <= '0;
            bin      <= '0;
            asleep_q <= 1'b0;
        end else if (sleep) begin
            therm    <= '0;
            bin      <= '0;
            asleep_q <= 1'b1;
        end else begin
            therm    <= therm_d;
            bin      <= code_q[BIN_W-1:0];
            asleep_q <= 1'b0;
        end
    end

    seg_weight_sum #(.SEG_W(SEG_W), .BIN_W(BIN_W)) u_wt (
        .therm   (therm),
        .bin     (bin),
        .asleep  (asleep_q),
        .wt_true (wt_true),
        .wt_comp (wt_comp)
    );

    AST_THERM_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        ((therm & (therm + 1'b1)) == '0)); // R3
    AST_SEG_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sleep)) |->
        ($countones(therm) == int'($past(code_q[CODE_W-1:BIN_W])))); // R3
    AST_BIN_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sleep)) |-> (bin == $past(code_q[BIN_W-1:0]))); // R4
    AST_WEIGHT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sleep)) |-> (wt_true == $past(code_q))); // R6
    AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sleep)) |-> (therm == '0 && bin == '0 && wt_comp == '0)); // R8
endmodule

// File: rtl/seg_dac_frontend.sv
// Top level: two independent channels that share only the sleep request.
// Assumes each reset is synchronous to its own channel clock.
module seg_dac_frontend (
    input  logic        i_clk,
    input  logic        i_rst_n,
    input  logic [9:0]  i_code,
    input  logic        q_clk,
    input  logic        q_rst_n,
    input  logic [9:0]  q_code,
    input  logic        sleep,
    output logic [30:0] i_therm,
    output logic [4:0]  i_bin,
    output logic [9:0]  i_wt_true,
    output logic [9:0]  i_wt_comp,
    output logic [30:0] q_therm,
    output logic [4:0]  q_bin,
    output logic [9:0]  q_wt_true,
    output logic [9:0]  q_wt_comp
);
    import seg_dac_pkg::*;

    seg_channel #(.SEG_W(SEG_W), .BIN_W(BIN_W)) u_ch_i (
        .clk (i_clk), .rst_n (i_rst_n), .code (i_code), .sleep (sleep),
        .therm (i_therm), .bin (i_bin), .wt_true (i_wt_true), .wt_comp (i_wt_comp)
    );

    seg_channel #(.SEG_W(SEG_W), .BIN_W(BIN_W)) u_ch_q (
        .clk (q_clk), .rst_n (q_rst_n), .code (q_code), .sleep (sleep),
        .therm (q_therm), .bin (q_bin), .wt_true (q_wt_true), .wt_comp (q_wt_comp)
    );
endmodule

// File: tb/seg_dac_frontend_test.sv
module seg_dac_frontend_test;
    localparam int CLK_PERIOD = 10;
    localparam int Q_PERIOD   = CLK_PERIOD + 4;

    typedef struct packed { logic [9:0] code; logic sl; } item_t;

    logic        i_clk = 0, q_clk = 0, i_rst_n = 0, q_rst_n = 0, sleep = 0;
    logic [9:0]  i_code = '0, q_code = '0;
    logic [30:0] i_therm, q_therm;
    logic [4:0]  i_bin, q_bin;
    logic [9:0]  i_wt_true, i_wt_comp, q_wt_true, q_wt_comp;

    int checks = 0, failures = 0;
    bit mon_i = 0, mon_q = 0, done = 0;
    item_t iq_exp[$];
    item_t qq_exp[$];
    int prev_i = -1, prev_q = -1, prevcnt_i = 0, prevcnt_q = 0;

    always #(CLK_PERIOD/2) i_clk = ~i_clk;
    always #(Q_PERIOD/2)   q_clk = ~q_clk;

    seg_dac_frontend uut (
        .i_clk(i_clk), .i_rst_n(i_rst_n), .i_code(i_code),
        .q_clk(q_clk), .q_rst_n(q_rst_n), .q_code(q_code), .sleep(sleep),
        .i_therm(i_therm), .i_bin(i_bin), .i_wt_true(i_wt_true), .i_wt_comp(i_wt_comp),
        .q_therm(q_therm), .q_bin(q_bin), .q_wt_true(q_wt_true), .q_wt_comp(q_wt_comp)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare one channel's outputs against an expected code and sleep state.
    task automatic score(input string ch, input logic [9:0] c, input logic sl,
                         input logic [30:0] th, input logic [4:0] bn,
                         input logic [9:0] wt, input logic [9:0] wc,
                         inout int prev, inout int prevcnt);
        logic [31:0] th_exp;
        th_exp = (32'd1 << c[9:5]) - 32'd1;
        if (sl) begin
            chk(th == '0 && bn == '0 && wt == '0 && wc == '0, {"R8 sleep ", ch}, {th, bn}, 0);
            prev = -1;
        end else begin
            chk(th == th_exp[30:0], {"R3 therm ", ch}, th, th_exp[30:0]);
            chk(bn == c[4:0], {"R4 bin ", ch}, bn, c[4:0]);
            chk(wt == c, {"R6 true weight ", ch}, wt, c);
            chk(wc == 10'd1023 - c && 11'(wt) + 11'(wc) == 11'd1023,
                {"R7 comp weight ", ch}, wc, 10'd1023 - c);
            if (c[4:0] == 5'd0 && c != 0 && prev == int'(c) - 1)
                chk(bn == 0 && $countones(th) == prevcnt + 1, {"R5 carry ", ch},
                    $countones(th), prevcnt + 1);
            prev = int'(c);
            prevcnt = $countones(th);
        end
    endtask

    // Monitor for channel I: output after edge k+1 belongs to item of edge k.
    always @(posedge i_clk) begin
        item_t e;
        #2;
        if (mon_i && iq_exp.size() >= 2) begin
            e = iq_exp.pop_front();
            score("I", e.code, iq_exp[0].sl, i_therm, i_bin, i_wt_true, i_wt_comp, prev_i, prevcnt_i);
        end
    end

    // Monitor for channel Q.
    always @(posedge q_clk) begin
        item_t e;
        #2;
        if (mon_q && qq_exp.size() >= 2) begin
            e = qq_exp.pop_front();
            score("Q", e.code, qq_exp[0].sl, q_therm, q_bin, q_wt_true, q_wt_comp, prev_q, prevcnt_q);
        end
    end

    task automatic drive_i(input logic [9:0] c, input logic sl);
        @(negedge i_clk);
        i_code = c;
        sleep = sl;
        iq_exp.push_back('{code: c, sl: sl});
    endtask

    task automatic drive_q(input logic [9:0] c);
        @(negedge q_clk);
        q_code = c;
        qq_exp.push_back('{code: c, sl: 1'b0});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge q_clk);
        chk(i_therm == 0 && i_bin == 0, "R1 I controls", {i_therm, i_bin}, 0);
        chk(i_wt_true == 0 && i_wt_comp == 10'd1023, "R1 I weights", i_wt_comp, 1023);
        chk(q_therm == 0 && q_bin == 0 && q_wt_true == 0 && q_wt_comp == 10'd1023,
            "R1 Q state", q_wt_comp, 1023);
        @(negedge i_clk); i_rst_n = 1;
        @(negedge q_clk); q_rst_n = 1;

        // R2: two-edge latency on I
        @(negedge i_clk); i_code = 10'd700;
        @(posedge i_clk); #2;
        chk(i_wt_true == 0, "R2 not yet after first edge", i_wt_true, 0);
        @(posedge i_clk); #2;
        chk(i_wt_true == 10'd700, "R2 present after second edge", i_wt_true, 700);

        // R3 R4 R5 R6 R7: full ramps on both channels in parallel
        mon_i = 1; mon_q = 1;
        fork
            begin
                for (int c = 0; c < 1024; c++) drive_i(10'(c), 1'b0);
                repeat (3) drive_i(10'd1023, 1'b0);
            end
            begin
                for (int c = 0; c < 1024; c++) drive_q(10'(c));
                repeat (3) drive_q(10'd1023);
            end
        join
        repeat (3) @(negedge q_clk);
        mon_q = 0; qq_exp.delete();

        // Mixed I pattern with sleep windows (R8); Q not scored here
        drive_i(10'd31, 0); drive_i(10'd32, 0); drive_i(10'd512, 0);
        drive_i(10'd511, 1); drive_i(10'd1023, 1); drive_i(10'd300, 1);
        drive_i(10'd300, 0); drive_i(10'd63, 0); drive_i(10'd64, 0);
        drive_i(10'd0, 1); drive_i(10'd777, 0); drive_i(10'd777, 0); drive_i(10'd777, 0);
        repeat (2) @(negedge i_clk);
        mon_i = 0; iq_exp.delete();
        repeat (3) @(negedge q_clk);

        // R9: resetting I leaves Q untouched
        @(negedge i_clk); i_rst_n = 0;
        repeat (2) @(negedge i_clk);
        chk(i_wt_true == 0 && i_therm == 0, "R9 I reset took effect", i_wt_true, 0);
        chk(q_wt_true == 10'd1023 && q_therm == '1 && q_bin == '1,
            "R9 Q unaffected by I reset", q_wt_true, 1023);
        i_rst_n = 1;
        finish_run();
    end
endmodule